// File: doc/BRIEF.md
# Three-Source Vectored Interrupt Controller

This block collects interrupt requests from three timer-type sources of a small microcontroller core: a time-base counter and two sampling-rate counters. Each source pulses its request input for one cycle. The pulse sets a sticky flag that stays pending until the core services it or software clears it.

The request flags, one enable per source and a master enable share a single 8-bit control register. The core reads and writes that register through a plain register port at data address 0x0B. When the master enable is set and at least one enabled flag is pending, the block drives an interrupt request to the core. It also drives the vector of the highest-priority pending source. When the core acknowledges, the block clears that source's flag and the master enable. Nesting is therefore impossible until software sets the master enable again.

Top module: `irq_ctl3`

## Requirements
- R1: After reset the control register reads 0x00, `irq_out` is low and `irq_vec` is 0x00.
- R2: A write with `bus_addr` equal to 0x0B loads the control register. The bit layout is: bit0 master enable; bit1, bit2 and bit3 enable the time-base, sample-1 and sample-2 sources; bit4, bit5 and bit6 are the flags of those same three sources. Bit7 always reads 0.
- R3: A high level on `req[i]` sets flag i in the next cycle, where i=0 is time-base, i=1 is sample-1 and i=2 is sample-2. A set flag stays set until a register write or an acknowledge clears it.
- R4: `irq_out` is high exactly when the master enable is set and some flag is set together with its own enable. A pending flag whose enable or master enable is clear raises nothing and stays held.
- R5: Among the enabled pending sources, the time-base source wins, then sample-1, then sample-2. `irq_vec` is 0x04, 0x08 or 0x0C for the winner, respectively.
- R6: When `irq_ack` is high while `irq_out` is high, the next cycle shows the vectored source's flag cleared and the master enable cleared. The other flags and the enables are unchanged.
- R7: If a request for a source arrives in the same cycle as a register write that clears its flag, the flag ends up set.
- R8: A write to any other address changes nothing, and a read of any other address returns 0x00.
- R9: `irq_ack` while `irq_out` is low has no effect. `irq_vec` is 0x00 whenever `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register port address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| req | input | 3 | Request pulses: bit0 time-base, bit1 sample-1, bit2 sample-2 |
| irq_ack | input | 1 | Core acknowledge of the current interrupt |
| irq_out | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector address of the winning source |

## Verification
The assertions check the following on every cycle:
- a request always lands in its flag;
- flags hold unless a write or an acknowledge clears them;
- the interrupt never rises without the master enable;
- an accepted acknowledge drops the master enable;
- the vector order favours the time-base source, and the vector is zero when idle.

Only the bench scenarios can show the remaining behaviour. This covers the exact read-back layout, and the fact that other flags survive an acknowledge. It also covers writes to other addresses being ignored, and a request colliding with a clearing write.

// File: rtl/irq_ctl3.sv
module irq_ctl3 #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'h0B,
  parameter logic [7:0]  VEC_TB   = 8'h04,
  parameter logic [7:0]  VEC_S1   = 8'h08,
  parameter logic [7:0]  VEC_S2   = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [2:0]        req,
  input  logic              irq_ack,
  output logic              irq_out,
  output logic [7:0]        irq_vec
);
  localparam int NSRC = 3;

  logic [6:0]      ctl, ctl_nxt;
  logic [NSRC-1:0] live, grant;
  logic            hit, take;

  assign hit   = (bus_addr == ADDR_W'(REG_ADDR));
  assign live  = ctl[6:4] & ctl[3:1];
  assign irq_out = ctl[0] & (|live);
  assign grant = !ctl[0] ? 3'b000 :
                 live[0] ? 3'b001 :
                 live[1] ? 3'b010 :
                 live[2] ? 3'b100 : 3'b000;
  assign irq_vec = grant[0] ? VEC_TB :
                   grant[1] ? VEC_S1 :
                   grant[2] ? VEC_S2 : 8'h00;
  assign bus_rdata = hit ? {1'b0, ctl} : 8'h00;
  assign take = irq_ack & irq_out;

  always_comb begin
    ctl_nxt = (bus_wr && hit) ? bus_wdata[6:0] : ctl;
    if (take) begin
      ctl_nxt[6:4] = ctl_nxt[6:4] & ~grant;
      ctl_nxt[0]   = 1'b0;
    end
    ctl_nxt[6:4] = ctl_nxt[6:4] | req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl <= '0;
    else        ctl <= ctl_nxt;
  end
endmodule

// File: rtl/irq_ctl3_chk.sv
module irq_ctl3_chk #(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] REG_ADDR = 8'h0B,
  parameter logic [7:0] VEC_TB   = 8'h04,
  parameter logic [7:0] VEC_S2   = 8'h0C
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [2:0]        req,
  input logic              irq_ack,
  input logic              irq_out,
  input logic [7:0]        irq_vec,
  input logic [6:0]        ctl
);
  logic wr_hit;
  assign wr_hit = bus_wr && (bus_addr == ADDR_W'(REG_ADDR));

  p_req_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |=> ctl[4]);
  p_flag_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[5] && !wr_hit && !(irq_ack && irq_out)) |=> ctl[5]);
  p_needs_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ctl[0]);
  p_tb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && ctl[4] && ctl[1]) |-> irq_vec == VEC_TB);
  p_s2_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec == VEC_S2) |-> !(ctl[5] && ctl[2]));
  p_ack_drops_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_out) |=> !ctl[0]);
  p_idle_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> irq_vec == 8'h00);
endmodule

bind irq_ctl3 irq_ctl3_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
  .VEC_TB(VEC_TB), .VEC_S2(VEC_S2)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .req(req), .irq_ack(irq_ack), .irq_out(irq_out), .irq_vec(irq_vec),
  .ctl(ctl));

// File: tb/irq_ctl3_test.sv
module irq_ctl3_test;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata, irq_vec;
  logic       bus_wr = 0, irq_ack = 0, irq_out;
  logic [2:0] req = 0;

  int total = 0, bad = 0, ncyc = 0;
  bit m_emi;
  bit m_en[3];
  bit m_flag[3];

  always #(CLK_P/2) clk = ~clk;

  irq_ctl3 uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req(req), .irq_ack(irq_ack),
    .irq_out(irq_out), .irq_vec(irq_vec));

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 5000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int winner();
    if (!m_emi) return -1;
    for (int i = 0; i < 3; i++) if (m_flag[i] && m_en[i]) return i;
    return -1;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(logic [7:0] a, logic w, logic [7:0] d, logic [2:0] r,
                     logic k, string tag);
    int win, rd;
    bus_addr = a; bus_wr = w; bus_wdata = d; req = r; irq_ack = k;
    #1;
    win = winner();
    rd = 0;
    if (a == 8'h0B) begin
      rd = m_emi;
      for (int i = 0; i < 3; i++) rd |= (int'(m_en[i]) << (i+1)) | (int'(m_flag[i]) << (i+4));
    end
    check(tag, "irq_out", irq_out, win >= 0);
    check(tag, "irq_vec", irq_vec, win >= 0 ? 4*(win+1) : 0);
    check(tag, "bus_rdata", bus_rdata, rd);
    @(posedge clk);
    if (!rst_n) begin
      m_emi = 0;
      for (int i = 0; i < 3; i++) begin m_en[i] = 0; m_flag[i] = 0; end
    end else begin
      if (w && a == 8'h0B) begin
        m_emi = d[0];
        for (int i = 0; i < 3; i++) begin m_en[i] = d[i+1]; m_flag[i] = d[i+4]; end
      end
      if (k && win >= 0) begin m_flag[win] = 0; m_emi = 0; end
      for (int i = 0; i < 3; i++) if (r[i]) m_flag[i] = 1;
    end
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    cyc(8'h0B, 0, 0, 3'b000, 0, "R1");
    cyc(8'h0B, 0, 0, 3'b000, 0, "R1");
    rst_n = 1;
    cyc(8'h0B, 0, 0, 3'b000, 0, "R1");
    cyc(8'h0B, 1, 8'hFF, 3'b000, 0, "R2");
    cyc(8'h0B, 0, 0, 3'b000, 0, "R2");
    cyc(8'h0B, 1, 8'h0E, 3'b000, 0, "R2");
    cyc(8'h0B, 0, 0, 3'b110, 0, "R3");
    cyc(8'h0B, 0, 0, 3'b000, 0, "R4");
    cyc(8'h0B, 1, 8'h61, 3'b000, 0, "R4");
    cyc(8'h0B, 0, 0, 3'b000, 0, "R4");
    cyc(8'h0B, 1, 8'h6F, 3'b001, 0, "R5");
    cyc(8'h0B, 0, 0, 3'b000, 0, "R5");
    cyc(8'h0B, 0, 0, 3'b000, 1, "R6");
    cyc(8'h0B, 0, 0, 3'b000, 1, "R9");
    cyc(8'h0B, 1, 8'h6F, 3'b000, 0, "R5");
    cyc(8'h0B, 0, 0, 3'b000, 1, "R6");
    cyc(8'h0B, 1, 8'h4F, 3'b000, 0, "R5");
    cyc(8'h0B, 1, 8'h0F, 3'b100, 0, "R7");
    cyc(8'h0B, 0, 0, 3'b000, 0, "R7");
    cyc(8'h0A, 1, 8'h00, 3'b000, 0, "R8");
    cyc(8'h2B, 1, 8'h00, 3'b000, 0, "R8");
    cyc(8'h0B, 0, 0, 3'b000, 0, "R8");
    cyc(8'h0B, 1, 8'h7F, 3'b000, 1, "R6");
    cyc(8'h0B, 0, 0, 3'b001, 0, "R3");
    cyc(8'h0B, 1, 8'h7E, 3'b000, 0, "R9");
    cyc(8'h0B, 0, 0, 3'b000, 1, "R9");
    cyc(8'h0B, 0, 0, 3'b000, 0, "R9");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule